// File: doc/BRIEF.md
# Command/Response Buffer Control Register Block

This block is the control and status register file of a trusted-module command/response buffer interface. A host reaches it through a simple memory-mapped port. Accesses may be 1 to 4 bytes wide and are little-endian. The block reports fixed interface identification words and the size and address of the command and response buffers. It also tracks locality ownership and a ready/idle control state.

Software places a command in the buffer, which is held outside this block, and then rings the start doorbell. The block then sends a one-cycle request strobe to a back-end engine. The strobe carries the request length, which is the shorter of the command header length and the back-end buffer size. The doorbell stays set until the back end reports completion. A cancel write is passed on to the back end only while a command is outstanding. A completion that carries an error sets a fatal status bit, and that bit stays set until reset.

Top module: `crb_regs`

## Requirements
- R1: A read (req_i=1, we_i=0) returns the 32-bit word that contains addr_i, shifted right by 8 times addr_i[1:0]. Word offsets 0x30 to 0x3F read as zero. rdata_o is zero when no read is presented.
- R2: A write whose value is exactly 1 to the start word (offset 0x1C) sets the invoke bit (bit 0 of that word) when it is clear. In the next cycle be_req_o is high for exactly one cycle. A start write with any other value, or one made while invoke is already set, changes nothing.
- R3: be_len_o, sampled while be_req_o is high, equals min(cmd_len_i, be_size_i) as those inputs stood at the start write.
- R4: A write of exactly 1 to the cancel word (offset 0x18) while invoke is set gives a one-cycle be_cancel_o in the next cycle. A cancel write with any other value, or one made while invoke is clear, gives no pulse.
- R5: be_done_i while invoke is set clears invoke. be_done_i while invoke is clear is ignored, and this holds for be_err_i as well.
- R6: A completion accepted with be_err_i=1 sets the fatal bit, bit 0 of the control status word (offset 0x14). Only reset clears that bit.
- R7: Writing 1 to the control request word (offset 0x10) clears the idle bit, bit 1 of the control status word. Writing 2 sets it. Any other value is ignored. The idle bit resets to 0.
- R8: Writing 1 to the locality control word (offset 0x04) sets the granted bit (bit 0 of the locality status word, offset 0x08) and the assigned bit (bit 1 of the locality state word, offset 0x00). Writing 2 clears both. Any other value is ignored, including a seize (4) or an establishment reset (8). Bit 0 of the locality state word always reads 1.
- R9: The interface ID word (offset 0x0C) reads 0x00025811. Its fields are: type=1 in [3:0], version=1 in [7:4], locality-0-only=0 in [8], fast idle=0 in [9], transfer size code 3 (64 bytes) in [12:11], FIFO=0 in [13], CRB=1 in [14], selector=1 in [18:17].
- R10: The command size (0x20) and response size (0x28) words read WIN_SIZE-BUF_OFF (0xF80 by default). The command address (0x24) and response address (0x2C) words read WIN_BASE+BUF_OFF (0xFED40080 by default). Writes to these words and to the ID word are discarded.
- R11: A write acts on the word that contains addr_i. Its value is the low size_i+1 bytes of wdata_i (size_i = byte count minus 1), with the upper bytes taken as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte address within the register window |
| size_i | input | 2 | Access size in bytes minus one |
| wdata_i | input | 32 | Write data, least significant byte first |
| rdata_o | output | 32 | Read data, valid in the same cycle as the read |
| cmd_len_i | input | LEN_W | Length taken from the command header |
| be_size_i | input | LEN_W | Back-end buffer size |
| be_req_o | output | 1 | One-cycle request strobe to the back end |
| be_len_o | output | LEN_W | Request length, valid with be_req_o |
| be_cancel_o | output | 1 | One-cycle cancel strobe to the back end |
| be_done_i | input | 1 | Back-end completion |
| be_err_i | input | 1 | Completion carries an error |

## Verification
The doorbell is exercised with an exact 1, with values such as 3 or 0x101 that hold a 1 bit but are not 1, and with repeated rings while busy. Together these show an exact-value compare apart from a bit test, and show that the edge-triggered latch differs from a level one. Cancels are issued both while idle and while busy. Completions are issued while idle and while busy, with and without error, which separates gating by the busy state from plain pulse forwarding. The error also stays sticky through later error-free commands. Narrow and unaligned accesses show the lane masking on writes and the byte shift on reads. Request lengths on each side of the back-end size check the minimum.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int IDX_W  = 4;
  localparam int ADDR_W = IDX_W + 2;

  localparam logic [IDX_W-1:0] IDX_LOC_STATE = 4'd0;
  localparam logic [IDX_W-1:0] IDX_LOC_CTRL  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_LOC_STS   = 4'd2;
  localparam logic [IDX_W-1:0] IDX_INTF_ID   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_CTRL_REQ  = 4'd4;
  localparam logic [IDX_W-1:0] IDX_CTRL_STS  = 4'd5;
  localparam logic [IDX_W-1:0] IDX_CANCEL    = 4'd6;
  localparam logic [IDX_W-1:0] IDX_START     = 4'd7;
  localparam logic [IDX_W-1:0] IDX_CMD_SIZE  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_CMD_ADDR  = 4'd9;
  localparam logic [IDX_W-1:0] IDX_RSP_SIZE  = 4'd10;
  localparam logic [IDX_W-1:0] IDX_RSP_ADDR  = 4'd11;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
    logic [31:0]      val;
  } wr_cmd_t;

  function automatic logic [31:0] intf_id_word();
    logic [31:0] w;
    w        = '0;
    w[3:0]   = 4'd1;  // type: active
    w[7:4]   = 4'd1;  // version
    w[8]     = 1'b0;  // locality 0 only
    w[9]     = 1'b0;  // fast idle
    w[12:11] = 2'b11; // 64-byte transfers
    w[13]    = 1'b0;  // no FIFO
    w[14]    = 1'b1;  // buffer interface supported
    w[18:17] = 2'd1;  // selector
    return w;
  endfunction
endpackage

// File: rtl/crb_wr_dec.sv
module crb_wr_dec
  import crb_pkg::*;
(
  input  logic             req_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      wdata_i,
  output wr_cmd_t          wr_o
);
  logic [31:0] lane_mask;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign lane_mask[8*b +: 8] = {8{size_i >= 2'(b)}};
  end

  assign wr_o.en  = req_i & we_i;
  assign wr_o.idx = idx_i;
  assign wr_o.val = wdata_i & lane_mask;
endmodule

// File: rtl/crb_cmd_ctrl.sv
module crb_cmd_ctrl
  import crb_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_cmd_t          wr_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [LEN_W-1:0] be_size_i,
  input  logic             be_done_i,
  input  logic             be_err_i,
  output logic             invoke_o,
  output logic             fatal_o,
  output logic             idle_o,
  output logic             be_req_o,
  output logic [LEN_W-1:0] be_len_o,
  output logic             be_cancel_o
);
  logic invoke_q, fatal_q, idle_q, req_q, cancel_q;
  logic [LEN_W-1:0] len_q;
  logic start_fire, cancel_fire, finish, ctrl_wr;

  assign start_fire  = wr_i.en && wr_i.idx == IDX_START  && wr_i.val == 32'd1 && !invoke_q;
  assign cancel_fire = wr_i.en && wr_i.idx == IDX_CANCEL && wr_i.val == 32'd1 && invoke_q;
  assign finish      = be_done_i && invoke_q;
  assign ctrl_wr     = wr_i.en && wr_i.idx == IDX_CTRL_REQ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      invoke_q <= 1'b0;
      fatal_q  <= 1'b0;
      idle_q   <= 1'b0;
      req_q    <= 1'b0;
      cancel_q <= 1'b0;
      len_q    <= '0;
    end else begin
      req_q    <= start_fire;
      cancel_q <= cancel_fire;
      if (start_fire) begin
        invoke_q <= 1'b1;
        len_q    <= (cmd_len_i < be_size_i) ? cmd_len_i : be_size_i;
      end else if (finish) begin
        invoke_q <= 1'b0;
      end
      if (finish && be_err_i) fatal_q <= 1'b1;
      if (ctrl_wr) begin
        if (wr_i.val == 32'd1)      idle_q <= 1'b0;
        else if (wr_i.val == 32'd2) idle_q <= 1'b1;
      end
    end
  end

  assign invoke_o    = invoke_q;
  assign fatal_o     = fatal_q;
  assign idle_o      = idle_q;
  assign be_req_o    = req_q;
  assign be_len_o    = len_q;
  assign be_cancel_o = cancel_q;

  // R2
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o |=> !be_req_o);
  // R2
  req_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o |-> invoke_q && !$past(invoke_q));
  // R4
  cancel_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_cancel_o |-> $past(invoke_q));
  // R6
  fatal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_q |=> fatal_q);
  // R5
  stray_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_done_i && be_err_i && !invoke_q && !fatal_q) |=> !fatal_q);
  // R3
  len_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_req_o |-> be_len_o <= $past(be_size_i) && be_len_o <= $past(cmd_len_i));
endmodule

// File: rtl/crb_loc.sv
module crb_loc
  import crb_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_cmd_t wr_i,
  output logic    granted_o
);
  logic granted_q;
  logic loc_wr;

  assign loc_wr = wr_i.en && wr_i.idx == IDX_LOC_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      granted_q <= 1'b0;
    end else if (loc_wr) begin
      if (wr_i.val == 32'd1)      granted_q <= 1'b1;
      else if (wr_i.val == 32'd2) granted_q <= 1'b0;
    end
  end

  assign granted_o = granted_q;

  // R8
  loc_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_wr && wr_i.val != 32'd1 && wr_i.val != 32'd2) |=> $stable(granted_q));
endmodule

// File: rtl/crb_regs.sv
module crb_regs
  import crb_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'hFED4_0000,
  parameter int          WIN_SIZE = 4096,
  parameter int          BUF_OFF  = 128,
  parameter int          LEN_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic [LEN_W-1:0]  be_size_i,
  output logic              be_req_o,
  output logic [LEN_W-1:0]  be_len_o,
  output logic              be_cancel_o,
  input  logic              be_done_i,
  input  logic              be_err_i
);
  localparam logic [31:0] BUF_SIZE_W = 32'(WIN_SIZE - BUF_OFF);
  localparam logic [31:0] BUF_ADDR_W = WIN_BASE + 32'(BUF_OFF);

  wr_cmd_t          wr;
  logic [IDX_W-1:0] idx;
  logic             invoke, fatal, idle, granted;
  logic [31:0]      word;

  assign idx = addr_i[ADDR_W-1:2];

  crb_wr_dec i_wr_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .idx_i  (idx),
    .size_i (size_i),
    .wdata_i(wdata_i),
    .wr_o   (wr)
  );

  crb_cmd_ctrl #(.LEN_W(LEN_W)) i_cmd_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .cmd_len_i  (cmd_len_i),
    .be_size_i  (be_size_i),
    .be_done_i  (be_done_i),
    .be_err_i   (be_err_i),
    .invoke_o   (invoke),
    .fatal_o    (fatal),
    .idle_o     (idle),
    .be_req_o   (be_req_o),
    .be_len_o   (be_len_o),
    .be_cancel_o(be_cancel_o)
  );

  crb_loc i_loc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .granted_o(granted)
  );

  always_comb begin
    case (idx)
      IDX_LOC_STATE: word = {30'd0, granted, 1'b1};
      IDX_LOC_STS:   word = {31'd0, granted};
      IDX_INTF_ID:   word = intf_id_word();
      IDX_CTRL_STS:  word = {30'd0, idle, fatal};
      IDX_START:     word = {31'd0, invoke};
      IDX_CMD_SIZE,
      IDX_RSP_SIZE:  word = BUF_SIZE_W;
      IDX_CMD_ADDR,
      IDX_RSP_ADDR:  word = BUF_ADDR_W;
      default:       word = '0;
    endcase
  end

  assign rdata_o = (req_i && !we_i) ? (word >> {addr_i[1:0], 3'b000}) : '0;

  // R1
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> rdata_o == '0);
  // R5
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_done_i && invoke) |=> !invoke);
endmodule

// File: tb/test_crb_regs.sv
`timescale 1ns/1ps
module test_crb_regs;
  localparam int LEN_W = 16;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [5:0] addr = '0;
  logic [1:0] size = 2'd3;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [LEN_W-1:0] cmd_len = 16'd100, be_size = 16'd64;
  logic be_req, be_cancel, done = 0, err = 0;
  logic [LEN_W-1:0] be_len;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  crb_regs i_crb_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .cmd_len_i(cmd_len),
    .be_size_i(be_size), .be_req_o(be_req), .be_len_o(be_len),
    .be_cancel_o(be_cancel), .be_done_i(done), .be_err_i(err)
  );

  // reference model
  bit m_inv, m_fatal, m_idle, m_grant, m_req, m_cancel;
  int m_len;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_inv <= 0; m_fatal <= 0; m_idle <= 0; m_grant <= 0;
      m_req <= 0; m_cancel <= 0; m_len <= 0;
    end else begin
      int v, w;
      v = 0;
      for (int b = 0; b <= int'(size); b++) v |= int'(wdata) & (32'hFF << (8*b));
      w = int'(addr) / 4;
      m_req <= 0;
      m_cancel <= 0;
      if (req && we) begin
        if (w == 7 && v == 1 && !m_inv) begin
          m_inv <= 1; m_req <= 1;
          m_len <= (cmd_len < be_size) ? int'(cmd_len) : int'(be_size);
        end
        if (w == 6 && v == 1 && m_inv) m_cancel <= 1;
        if (w == 4 && v == 1) m_idle <= 0;
        if (w == 4 && v == 2) m_idle <= 1;
        if (w == 1 && v == 1) m_grant <= 1;
        if (w == 1 && v == 2) m_grant <= 0;
      end
      if (done && m_inv) begin
        m_inv <= 0;
        if (err) m_fatal <= 1;
      end
    end
  end

  function automatic logic [31:0] m_read(logic [5:0] a);
    logic [31:0] x;
    case (a[5:2])
      0: x = {30'd0, m_grant, 1'b1};
      2: x = {31'd0, m_grant};
      3: x = 32'h0002_5811;
      5: x = {30'd0, m_idle, m_fatal};
      7: x = {31'd0, m_inv};
      8, 10: x = 32'h0000_0F80;
      9, 11: x = 32'hFED4_0080;
      default: x = '0;
    endcase
    return x >> (8 * a[1:0]);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison of the back-end strobes
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 be_req_o", 32'(be_req), 32'(m_req));
      chk("R4 be_cancel_o", 32'(be_cancel), 32'(m_cancel));
      if (m_req) chk("R3 be_len_o", 32'(be_len), 32'(m_len));
    end
  end

  task automatic wr(logic [5:0] a, logic [1:0] s, logic [31:0] d);
    @(posedge clk); #0.5;
    req = 1; we = 1; addr = a; size = s; wdata = d;
    @(posedge clk); #0.5;
    req = 0; we = 0; size = 2'd3;
  endtask

  task automatic rd(string tag, logic [5:0] a, logic [31:0] exp);
    @(posedge clk); #0.5;
    req = 1; we = 0; addr = a;
    #0.5;
    chk(tag, rdata, exp);
    chk({tag, " model"}, rdata, m_read(a));
    @(posedge clk); #0.5;
    req = 0;
  endtask

  task automatic complete(bit e);
    @(posedge clk); #0.5;
    done = 1; err = e;
    @(posedge clk); #0.5;
    done = 0; err = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    #0.5 chk("R1 no-read rdata", rdata, 32'h0);
    // reset values
    rd("R9 intf id", 6'h0C, 32'h0002_5811);
    rd("R10 cmd size", 6'h20, 32'h0000_0F80);
    rd("R10 cmd addr", 6'h24, 32'hFED4_0080);
    rd("R10 rsp size", 6'h28, 32'h0000_0F80);
    rd("R10 rsp addr", 6'h2C, 32'hFED4_0080);
    rd("R8 loc state reset", 6'h00, 32'h1);
    rd("R6 ctrl sts reset", 6'h14, 32'h0);
    rd("R2 start reset", 6'h1C, 32'h0);
    // byte-shifted and unmapped reads
    rd("R1 byte1 id", 6'h0D, 32'h0000_0258);
    rd("R1 byte3 id", 6'h0F, 32'h0);
    rd("R1 byte2 id", 6'h0E, 32'h0000_0002);
    rd("R1 byte1 addr", 6'h25, 32'h00FE_D400);
    rd("R1 unmapped", 6'h30, 32'h0);
    rd("R1 unmapped top", 6'h3C, 32'h0);
    // read-only words
    wr(6'h0C, 2'd3, 32'hFFFF_FFFF);
    rd("R10 id after write", 6'h0C, 32'h0002_5811);
    wr(6'h20, 2'd3, 32'h0000_0010);
    rd("R10 size after write", 6'h20, 32'h0000_0F80);
    wr(6'h24, 2'd1, 32'h0000_1234);
    rd("R10 addr after write", 6'h24, 32'hFED4_0080);
    // locality
    wr(6'h04, 2'd3, 32'h4);
    rd("R8 seize ignored", 6'h08, 32'h0);
    wr(6'h04, 2'd3, 32'h8);
    rd("R8 est reset ignored", 6'h00, 32'h1);
    wr(6'h04, 2'd3, 32'h1);
    rd("R8 granted", 6'h08, 32'h1);
    rd("R8 assigned", 6'h00, 32'h3);
    wr(6'h04, 2'd3, 32'h3);
    rd("R8 value 3 ignored", 6'h08, 32'h1);
    wr(6'h04, 2'd3, 32'h2);
    rd("R8 relinquished", 6'h00, 32'h1);
    // control request
    wr(6'h10, 2'd3, 32'h2);
    rd("R7 go idle", 6'h14, 32'h2);
    wr(6'h10, 2'd3, 32'h3);
    rd("R7 value 3 ignored", 6'h14, 32'h2);
    wr(6'h10, 2'd3, 32'h1);
    rd("R7 ready", 6'h14, 32'h0);
    // cancel while idle
    wr(6'h18, 2'd3, 32'h1);
    rd("R4 idle cancel no start", 6'h1C, 32'h0);
    // stray completion with error
    complete(1'b1);
    rd("R5 stray done ignored", 6'h14, 32'h0);
    // non-unit start values
    wr(6'h1C, 2'd3, 32'h3);
    rd("R2 value 3 ignored", 6'h1C, 32'h0);
    wr(6'h1C, 2'd1, 32'h0000_0101);
    rd("R11 two-byte 0x101 ignored", 6'h1C, 32'h0);
    // start, length clipped to back-end size
    cmd_len = 16'd100; be_size = 16'd64;
    wr(6'h1C, 2'd3, 32'h1);
    rd("R2 invoke set", 6'h1C, 32'h1);
    wr(6'h1C, 2'd3, 32'h1);
    rd("R2 repeat start ignored", 6'h1C, 32'h1);
    wr(6'h18, 2'd3, 32'h2);
    wr(6'h18, 2'd3, 32'h1);
    complete(1'b0);
    rd("R5 done clears invoke", 6'h1C, 32'h0);
    rd("R6 no error no fatal", 6'h14, 32'h0);
    // one-byte start with junk upper bytes, length from header
    cmd_len = 16'd20;
    wr(6'h1C, 2'd0, 32'h0000_0201);
    rd("R11 one-byte start", 6'h1C, 32'h1);
    complete(1'b1);
    rd("R6 fatal set", 6'h14, 32'h1);
    wr(6'h10, 2'd3, 32'h2);
    rd("R6 fatal kept", 6'h14, 32'h3);
    cmd_len = 16'd64;
    wr(6'h1F, 2'd0, 32'h1);
    complete(1'b0);
    rd("R6 fatal sticky", 6'h14, 32'h3);
    rd("R5 invoke clear", 6'h1C, 32'h0);
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule